// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This block gathers eight interrupt request lines into one interrupt line toward a host CPU. It keeps three 8-bit state registers. The pending register holds requests that have been seen. The mask register gates requests. The in-service register marks levels the CPU is currently handling. A resolver picks the request that is served next. Priority is either fixed, with level 0 on top, or rotating.

The CPU answers the interrupt with two acknowledge pulses. The first pulse freezes the winning level and moves it from pending to in-service. During the second pulse, the read bus carries a vector byte equal to a fixed base plus the level number. Service ends in one of three ways: a specific end-of-interrupt command, a non-specific one, or automatic clearing after the second pulse.

A small write port sets four things: the mask, the per-input trigger mode, the priority mode and the end-of-interrupt style. Outside the acknowledge phase, the same read bus returns whichever state register is selected.

Top module: `pic_core`

## Requirements
- R1: After reset, int_o is 0, the pending and in-service registers read 0x00, the mask reads 0xFF (all inputs blocked), and all inputs are edge-triggered. Priority is fixed and automatic EOI is off.
- R2: An edge-mode input sets its pending bit only on a 0-to-1 transition while unmasked. A line that stays high does not set the bit again. The bit is cleared by the first acknowledge pulse that selects it.
- R3: A request whose mask bit is 1 is neither recorded nor able to raise int_o. Masking one input has no effect on any other input.
- R4: In level mode, the pending bit follows the input (gated by the mask) one cycle later. A request that drops before acknowledge raises no interrupt.
- R5: With fixed priority, a lower level number wins. int_o is 1 only while the winning unmasked pending level ranks strictly above every in-service level.
- R6: The first rising acknowledge edge sets the winner's in-service bit and clears its pending bit. While acknowledge is high in the second pulse, rd_data_o equals VEC_BASE plus the level. With no valid winner, the vector uses level 7 and no in-service bit changes.
- R7: Writing address 3 with bit 3 = 1 clears the in-service bit named by bits 2:0.
- R8: Writing address 3 with bit 3 = 0 clears the highest-priority in-service bit.
- R9: With automatic EOI on, the in-service bit of the served level clears at the second acknowledge edge.
- R10: In rotating mode, the level whose in-service bit was last cleared becomes lowest priority. The level after it becomes highest.
- R11: Outside the vector phase, rd_sel_i picks what rd_data_o shows: 0 pending, 1 mask, 2 in-service, 3 trigger mode.
- R12: Writes use these addresses: address 0 is the mask (1 = blocked); address 1 is the trigger mode (1 = level); address 2 sets rotating priority with bit 0 and automatic EOI with bit 1; address 3 is the EOI command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Request lines, level 0 to 7 |
| inta_i | input | 1 | Acknowledge pulses from the CPU |
| int_o | output | 1 | Interrupt request to the CPU |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_sel_i | input | 2 | Status register select |
| rd_data_o | output | 8 | Status or vector byte |

## Verification
A corrupted pending or mask bit appears on int_o within one cycle of the faulty edge. A wrong rank order or rotation pointer appears on the vector byte of the very next acknowledge. A wrong in-service bit shows in two places: int_o stays low for a request that should nest, and readback select 2 returns a stale value. EOI and auto-clear faults therefore show within two acknowledge cycles of the command.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int IRQ_N = 8;
  localparam int LVL_W = $clog2(IRQ_N);

  typedef enum logic {ACK_IDLE, ACK_VEC} ack_st_e;

  // 0 = highest priority; low is the current lowest-priority level
  function automatic logic [LVL_W-1:0] prio_rank(input logic [LVL_W-1:0] idx,
                                                 input logic [LVL_W-1:0] low);
    return idx - low - LVL_W'(1);
  endfunction
endpackage

// File: rtl/pic_req.sv
module pic_req
  import pic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_N-1:0] irq_i,
  input  logic [IRQ_N-1:0] level_i,
  input  logic [IRQ_N-1:0] mask_i,
  input  logic [IRQ_N-1:0] clr_i,
  output logic [IRQ_N-1:0] irr_o
);
  logic [IRQ_N-1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          irr_o[g] <= 1'b0;
      else if (clr_i[g])    irr_o[g] <= 1'b0;
      else if (level_i[g])  irr_o[g] <= irq_i[g] & ~mask_i[g];
      else if (irq_i[g] && !irq_q[g] && !mask_i[g]) irr_o[g] <= 1'b1;
    end

    a_r2_edge_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_i[g] && irq_i[g] && !irq_q[g] && !mask_i[g] && !clr_i[g]) |=> irr_o[g]);
    a_r4_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_i[g] && !irq_i[g] && !clr_i[g]) |=> !irr_o[g]);
  end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_pkg::*;
(
  input  logic [IRQ_N-1:0] req_i,
  input  logic [LVL_W-1:0] low_i,
  output logic             vld_o,
  output logic [LVL_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    // walk from lowest to highest rank; last hit wins
    for (int k = IRQ_N - 1; k >= 0; k--) begin
      if (req_i[low_i + LVL_W'(1) + LVL_W'(k)]) idx_o = low_i + LVL_W'(1) + LVL_W'(k);
    end
    vld_o = |req_i;
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter logic [7:0] VEC_BASE = 8'h40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] irq_i,
  input  logic       inta_i,
  output logic       int_o,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [1:0] rd_sel_i,
  output logic [7:0] rd_data_o
);
  localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(IRQ_N - 1);

  ack_st_e          st_q;
  logic [IRQ_N-1:0] imr_q, trig_q, isr_q, irr_q;
  logic             rot_q, aeoi_q, inta_q, spur_q;
  logic [LVL_W-1:0] low_q, lvl_q, low_eff;

  logic             pend_vld, isr_vld, grant;
  logic [LVL_W-1:0] pend_idx, isr_idx;
  logic [IRQ_N-1:0] irr_clr, isr_set, isr_clr;
  logic             ack_rise, ack1, ack2, eoi_wr, eoi_hit, aeoi_hit;
  logic [LVL_W-1:0] eoi_lvl;

  assign low_eff  = rot_q ? low_q : LVL_LAST;
  assign ack_rise = inta_i & ~inta_q;
  assign ack1     = (st_q == ACK_IDLE) && ack_rise;
  assign ack2     = (st_q == ACK_VEC) && ack_rise;

  pic_req u_req (
    .clk_i, .rst_ni, .irq_i,
    .level_i (trig_q),
    .mask_i  (imr_q),
    .clr_i   (irr_clr),
    .irr_o   (irr_q)
  );

  pic_resolver u_pend_res (
    .req_i (irr_q & ~imr_q), .low_i (low_eff), .vld_o (pend_vld), .idx_o (pend_idx)
  );

  pic_resolver u_isr_res (
    .req_i (isr_q), .low_i (low_eff), .vld_o (isr_vld), .idx_o (isr_idx)
  );

  assign grant = pend_vld &&
                 (!isr_vld || (prio_rank(pend_idx, low_eff) < prio_rank(isr_idx, low_eff)));
  assign int_o = grant && (st_q == ACK_IDLE);

  assign eoi_wr   = wr_en_i && (wr_addr_i == 3'd3);
  assign eoi_lvl  = wr_data_i[3] ? wr_data_i[LVL_W-1:0] : isr_idx;
  assign eoi_hit  = eoi_wr && (wr_data_i[3] || isr_vld);
  assign aeoi_hit = ack2 && aeoi_q && !spur_q;

  always_comb begin
    irr_clr = '0;
    isr_set = '0;
    isr_clr = '0;
    if (ack1 && grant) begin
      irr_clr[pend_idx] = 1'b1;
      isr_set[pend_idx] = 1'b1;
    end
    if (eoi_hit)  isr_clr[eoi_lvl] = 1'b1;
    if (aeoi_hit) isr_clr[lvl_q]   = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ACK_IDLE;
      imr_q  <= '1;
      trig_q <= '0;
      isr_q  <= '0;
      rot_q  <= 1'b0;
      aeoi_q <= 1'b0;
      inta_q <= 1'b0;
      spur_q <= 1'b0;
      low_q  <= LVL_LAST;
      lvl_q  <= '0;
    end else begin
      inta_q <= inta_i;
      isr_q  <= (isr_q & ~isr_clr) | isr_set;
      if (wr_en_i) begin
        case (wr_addr_i)
          3'd0: imr_q  <= wr_data_i;
          3'd1: trig_q <= wr_data_i;
          3'd2: begin rot_q <= wr_data_i[0]; aeoi_q <= wr_data_i[1]; end
          default: ;
        endcase
      end
      if (rot_q && aeoi_hit)     low_q <= lvl_q;
      else if (rot_q && eoi_hit) low_q <= eoi_lvl;
      if (ack1) begin
        st_q   <= ACK_VEC;
        lvl_q  <= grant ? pend_idx : LVL_LAST;
        spur_q <= !grant;
      end else if (ack2) begin
        st_q <= ACK_IDLE;
      end
    end
  end

  always_comb begin
    if (st_q == ACK_VEC && inta_i) rd_data_o = VEC_BASE + 8'(lvl_q);
    else begin
      case (rd_sel_i)
        2'd0:    rd_data_o = irr_q;
        2'd1:    rd_data_o = imr_q;
        2'd2:    rd_data_o = isr_q;
        default: rd_data_o = trig_q;
      endcase
    end
  end

  a_r3_int_needs_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr_q & ~imr_q) != '0));
  a_r6_ack_sets_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack1 && grant) |=> isr_q[$past(pend_idx)]);
  a_r6_spurious_keeps_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack1 && !grant && !eoi_wr) |=> $stable(isr_q));
  a_r7_specific_eoi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && wr_data_i[3] && !ack_rise) |=> !isr_q[$past(wr_data_i[LVL_W-1:0])]);
  a_r9_auto_eoi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aeoi_hit |=> !isr_q[$past(lvl_q)]);
  a_r5_isr_grows_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack1 |=> ($countones(isr_q) <= $countones($past(isr_q)) + 1));
endmodule

// File: tb/tb_pic_core.sv
module tb_pic_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq_i = '0;
  logic       inta_i = 1'b0;
  logic       int_o;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] rd_sel_i = '0;
  logic [7:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  pic_core #(.VEC_BASE(8'h40)) dut (.*);

  localparam logic [3:0] OP_WR = 4'd0, OP_IRQ = 4'd1, OP_ACK1 = 4'd2, OP_ACK2 = 4'd3,
                         OP_INT = 4'd4, OP_RD = 4'd5;
  // {req, op, addr/sel, data/expected}
  localparam int NV = 58;
  localparam logic [19:0] TBL [NV] = '{
    {4'd1,  OP_RD,  4'd0, 8'h00},   // R1 pending
    {4'd1,  OP_RD,  4'd1, 8'hFF},   // R1 mask
    {4'd1,  OP_INT, 4'd0, 8'h00},   // R1
    {4'd3,  OP_IRQ, 4'd0, 8'h04},
    {4'd3,  OP_RD,  4'd0, 8'h00},   // R3 masked not recorded
    {4'd3,  OP_INT, 4'd0, 8'h00},   // R3
    {4'd12, OP_WR,  4'd0, 8'h00},
    {4'd12, OP_RD,  4'd1, 8'h00},   // R12 mask write
    {4'd2,  OP_RD,  4'd0, 8'h00},   // R2 steady high no edge
    {4'd2,  OP_IRQ, 4'd0, 8'h00},
    {4'd2,  OP_IRQ, 4'd0, 8'h24},
    {4'd2,  OP_RD,  4'd0, 8'h24},   // R2
    {4'd5,  OP_INT, 4'd0, 8'h01},   // R5
    {4'd6,  OP_ACK1,4'd0, 8'h00},
    {4'd6,  OP_ACK2,4'd0, 8'h42},   // R6 level 2 wins
    {4'd6,  OP_RD,  4'd2, 8'h04},   // R6
    {4'd2,  OP_RD,  4'd0, 8'h20},   // R2 cleared by ack
    {4'd5,  OP_INT, 4'd0, 8'h00},   // R5 blocked by service
    {4'd5,  OP_IRQ, 4'd0, 8'h25},
    {4'd5,  OP_INT, 4'd0, 8'h01},   // R5 nesting
    {4'd6,  OP_ACK1,4'd0, 8'h00},
    {4'd6,  OP_ACK2,4'd0, 8'h40},   // R6
    {4'd8,  OP_WR,  4'd3, 8'h00},
    {4'd8,  OP_RD,  4'd2, 8'h04},   // R8
    {4'd7,  OP_WR,  4'd3, 8'h0A},
    {4'd7,  OP_RD,  4'd2, 8'h00},   // R7
    {4'd3,  OP_WR,  4'd0, 8'h20},
    {4'd3,  OP_INT, 4'd0, 8'h00},   // R3 masked pending
    {4'd3,  OP_WR,  4'd0, 8'h00},
    {4'd3,  OP_INT, 4'd0, 8'h01},   // R3
    {4'd6,  OP_ACK1,4'd0, 8'h00},
    {4'd6,  OP_ACK2,4'd0, 8'h45},   // R6
    {4'd7,  OP_WR,  4'd3, 8'h0D},
    {4'd7,  OP_RD,  4'd2, 8'h00},   // R7
    {4'd9,  OP_WR,  4'd2, 8'h02},
    {4'd9,  OP_IRQ, 4'd0, 8'h00},
    {4'd9,  OP_IRQ, 4'd0, 8'h08},
    {4'd9,  OP_ACK1,4'd0, 8'h00},
    {4'd9,  OP_RD,  4'd2, 8'h08},   // R9 set before second pulse
    {4'd9,  OP_ACK2,4'd0, 8'h43},
    {4'd9,  OP_RD,  4'd2, 8'h00},   // R9
    {4'd10, OP_WR,  4'd2, 8'h03},
    {4'd10, OP_IRQ, 4'd0, 8'h00},
    {4'd10, OP_IRQ, 4'd0, 8'h09},
    {4'd10, OP_ACK1,4'd0, 8'h00},
    {4'd10, OP_ACK2,4'd0, 8'h40},   // R10 level 0 first
    {4'd10, OP_IRQ, 4'd0, 8'h08},
    {4'd10, OP_IRQ, 4'd0, 8'h09},
    {4'd10, OP_ACK1,4'd0, 8'h00},
    {4'd10, OP_ACK2,4'd0, 8'h43},   // R10 level 0 now lowest
    {4'd10, OP_ACK1,4'd0, 8'h00},
    {4'd10, OP_ACK2,4'd0, 8'h40},   // R10
    {4'd4,  OP_WR,  4'd2, 8'h00},
    {4'd4,  OP_WR,  4'd1, 8'h80},
    {4'd4,  OP_IRQ, 4'd0, 8'h80},
    {4'd4,  OP_INT, 4'd0, 8'h01},   // R4
    {4'd4,  OP_IRQ, 4'd0, 8'h00},
    {4'd4,  OP_INT, 4'd0, 8'h00}    // R4 dropped request
  };

  task automatic check(input int rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %02h expected %02h", rq, act, exp);
    end
  endtask

  task automatic tick2();
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0; inta_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic run_op(input logic [19:0] e);
    int rq; logic [3:0] op, a; logic [7:0] d;
    {op, a, d} = e[15:0];
    rq = int'(e[19:16]);
    case (op)
      OP_WR:   begin wr_en_i = 1'b1; wr_addr_i = a[2:0]; wr_data_i = d; tick2(); end
      OP_IRQ:  begin irq_i = d; tick2(); end
      OP_ACK1: begin inta_i = 1'b1; tick2(); end
      OP_ACK2: begin inta_i = 1'b1; #1 check(rq, rd_data_o, d); tick2(); end
      OP_INT:  check(rq, {7'd0, int_o}, d);
      default: begin rd_sel_i = a[1:0]; #1 check(rq, rd_data_o, d); end
    endcase
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) run_op(TBL[i]);

    // R4 level request held through acknowledge
    run_op({4'd4, OP_IRQ, 4'd0, 8'h80});
    run_op({4'd6, OP_ACK1, 4'd0, 8'h00});
    run_op({4'd6, OP_ACK2, 4'd0, 8'h47});
    run_op({4'd4, OP_RD, 4'd0, 8'h80});
    run_op({4'd5, OP_INT, 4'd0, 8'h00});
    run_op({4'd7, OP_WR, 4'd3, 8'h0F});
    run_op({4'd7, OP_INT, 4'd0, 8'h01});
    run_op({4'd11, OP_RD, 4'd3, 8'h80});   // R11 trigger readback
    run_op({4'd11, OP_RD, 4'd2, 8'h00});   // R11
    run_op({4'd4, OP_IRQ, 4'd0, 8'h00});
    // R6 spurious acknowledge
    run_op({4'd6, OP_ACK1, 4'd0, 8'h00});
    run_op({4'd6, OP_ACK2, 4'd0, 8'h47});
    run_op({4'd6, OP_RD, 4'd2, 8'h00});
    // R1 reset during activity
    run_op({4'd1, OP_IRQ, 4'd0, 8'h80});
    run_op({4'd1, OP_INT, 4'd0, 8'h01});
    rst_ni = 1'b0;
    #1 check(1, {7'd0, int_o}, 8'h00);     // R1
    rd_sel_i = 2'd1; #1 check(1, rd_data_o, 8'hFF);
    rd_sel_i = 2'd3; #1 check(1, rd_data_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1; irq_i = '0;
    @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule